// File: doc/BRIEF.md
# Exponential-Minus-One Operand Front End

This block sits at the entry of an extended-precision 2^x − 1 instruction. Each accepted operand is an 80-bit value: sign, 15-bit biased exponent and a 64-bit significand whose top bit is explicit. Alongside it the block takes the floating-point control word and the current status word. The block sorts the operand into its class. For every class with a closed-form answer it produces the result and the new status word itself. This covers zeros, NaNs, infinities, exact ±1, out-of-range magnitudes, invalid encodings and denormals. It also handles arguments so small that 2^x − 1 reduces to x·ln2.

For those tiny arguments the significand is multiplied by a fixed ln2 significand cut to 66 significant bits. The 192-bit product then goes through a normalise, round and underflow stage that honours the rounding mode and the masks. Operands in the mid range, with magnitude under one but not tiny, need a polynomial core that lives outside this block. For them the block raises a request flag and hands over the prepared status word. Every result appears one clock after its operand is accepted.

Top module: `exp2m1_front`

## Requirements
- R1: The output status word is built from the incoming condition bits C0 (bit 8), C2 (bit 10) and C3 (bit 14) only, with the stack-top field (bits 13:11) forced to 7. Every other bit starts at zero and is set only by the rules below: IE bit 0, DE bit 1, UE bit 4, PE bit 5, ES bit 7, C1 bit 9, B bit 15.
- R2: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. A synchronous active-low reset clears `out_valid` and `core_req`.
- R3: A normal operand (exponent neither 0 nor 0x7FFF, bit 63 set) with biased exponent in 16315..16382 raises `core_req`. Its result fields are all zero and its status is exactly the R1 seed.
- R4: A normal operand with biased exponent ≤ 16314 takes the tiny path. Its significand is multiplied by 0xB17217F7D1CF79AB_C000000000000000 into a 192-bit product, and bit 0 of the product is forced to 1. The result is normalised, taking the operand exponent as the starting biased exponent (1 for denormal and pseudo-denormal inputs), and the result sign is the operand sign.
- R5: Tiny-path rounding uses the control-word field in bits 11:10 (00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero) on the low 128 bits. An increment sets C1, and a carry out renormalises to 0x8000000000000000 with the exponent plus one. Any discarded bit sets PE, plus ES and B when PM (control bit 5) is clear.
- R6: Normalisation never drives the exponent below zero when UM (control bit 4) is set. If the rounded exponent is ≤ 0, UE is set. With UM set the exponent becomes 0 and a significand with bit 63 set is shifted right once. With UM clear the exponent is raised by 24576 and ES and B are set.
- R7: Exactly +1.0 gives +1.0 (exponent 16383). Exactly −1.0 gives −0.5 (exponent 16382). Both results carry significand 0x8000000000000000, and both set PE, plus ES and B when PM is clear.
- R8: Any other normal operand with biased exponent ≥ 16383 is returned unchanged, with the same PE/ES/B handling as R7.
- R9: Zero and quiet NaN operands (exponent 0x7FFF, bits 63 and 62 set), the indefinite value included, are returned unchanged with only the R1 seed as status.
- R10: +∞ (exponent 0x7FFF, significand 0x8000000000000000) returns +∞. −∞ returns −1.0 (sign 1, exponent 16383, significand 0x8000000000000000). Neither adds any flag.
- R11: A denormal (exponent 0, bit 63 clear, nonzero) or pseudo-denormal (exponent 0, bit 63 set) operand sets DE. With DM (control bit 1) set it takes the tiny path. With DM clear it is returned unchanged with ES and B set.
- R12: Unnormals (bit 63 clear, exponent neither 0 nor 0x7FFF), pseudo-NaNs (exponent 0x7FFF, bit 63 clear) and signalling NaNs all set IE. With IM (control bit 0) set, the unnormals and pseudo-NaNs return sign 1, exponent 0x7FFF, significand 0xC000000000000000, and a signalling NaN returns with bit 62 set. With IM clear the operand is returned unchanged with ES and B set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 15 | Operand biased exponent |
| in_mant | input | 64 | Operand significand, bit 63 explicit |
| ctrl_word | input | 16 | Floating-point control word |
| stat_word | input | 16 | Current status word |
| out_valid | output | 1 | Result present this cycle |
| res_sign | output | 1 | Result sign |
| res_exp | output | 15 | Result biased exponent |
| res_mant | output | 64 | Result significand |
| res_status | output | 16 | New status word |
| core_req | output | 1 | Operand needs the polynomial core |

## Verification
The assertions assume that `in_valid` is a clean 0/1 level changing only between edges, and that the control and status words are stable over the accepting edge. They also assume the operand fields belong to the same cycle as `in_valid`. The stimulus drives every field at the falling edge, holds `in_valid` for a single cycle and leaves an idle cycle before the next operand. It sweeps every operand class against all four rounding modes, several mask combinations and two incoming status words, including junk in the unused control bits.

// File: rtl/exp2m1_pkg.sv
// Package: shared widths, constants, field positions and the operand class type
// for the 2^x-1 front end. Assumes the 80-bit extended layout (1+15+64).
package exp2m1_pkg;
    localparam int EXP_W  = 15;
    localparam int MANT_W = 64;
    localparam int STAT_W = 16;
    localparam int PROD_W = 3 * MANT_W;
    localparam int EACC_W = 20;
    localparam int LZ_W   = $clog2(PROD_W);

    localparam logic [EXP_W-1:0]  EXP_BIAS   = 15'd16383;
    localparam logic [EXP_W-1:0]  EXP_TINY   = 15'd16314;
    localparam logic [EXP_W-1:0]  EXP_MAX    = 15'h7FFF;
    localparam logic [MANT_W-1:0] MANT_ONE   = 64'h8000_0000_0000_0000;
    localparam logic [MANT_W-1:0] MANT_INDEF = 64'hC000_0000_0000_0000;
    localparam logic [2*MANT_W-1:0] LN2_SIG  = 128'hB172_17F7_D1CF_79AB_C000_0000_0000_0000;
    localparam logic signed [EACC_W-1:0] UFLOW_ADJ = 20'sd24576;

    // status word bit positions
    localparam int SB_IE = 0, SB_DE = 1, SB_UE = 4, SB_PE = 5, SB_ES = 7;
    localparam int SB_C0 = 8, SB_C1 = 9, SB_C2 = 10, SB_TOP = 11, SB_C3 = 14, SB_B = 15;
    // control word bit positions
    localparam int CB_IM = 0, CB_DM = 1, CB_UM = 4, CB_PM = 5, CB_RC = 10;

    typedef enum logic [2:0] {
        CL_ZERO, CL_DENORM, CL_PDENORM, CL_NORMAL,
        CL_UNNORMAL, CL_INF, CL_PNAN, CL_NAN_Q
    } opclass_e;
    // signalling NaN shares the invalid handling; kept distinct by a flag
endpackage

// File: rtl/exp2m1_classify.sv
// Module: exp2m1_classify
// Sorts an 80-bit operand by exponent and explicit bit 63 into its class.
// Assumes nothing about the operand; every encoding maps to exactly one class.
module exp2m1_classify
    import exp2m1_pkg::*;
(
    input  logic [EXP_W-1:0]  op_exp,
    input  logic [MANT_W-1:0] op_mant,
    output opclass_e          op_class,
    output logic              op_snan
);
    // decode the class from the exponent extremes and the explicit bit
    always_comb begin
        op_snan = 1'b0;
        if (op_exp == '0) begin
            if (op_mant == '0)            op_class = CL_ZERO;
            else if (op_mant[MANT_W-1])   op_class = CL_PDENORM;
            else                          op_class = CL_DENORM;
        end else if (op_exp == EXP_MAX) begin
            if (!op_mant[MANT_W-1])       op_class = CL_PNAN;
            else if (op_mant[MANT_W-2:0] == '0) op_class = CL_INF;
            else if (op_mant[MANT_W-2])   op_class = CL_NAN_Q;
            else begin
                op_class = CL_PNAN;
                op_snan  = 1'b1;
            end
        end else begin
            op_class = op_mant[MANT_W-1] ? CL_NORMAL : CL_UNNORMAL;
        end
    end
endmodule

// File: rtl/exp2m1_tiny_round.sv
// Module: exp2m1_tiny_round
// Tiny-argument path: significand times truncated ln2, forced sticky bit,
// normalise, round by mode, then underflow handling. Purely combinational.
// Assumes op_mant is nonzero.
module exp2m1_tiny_round
    import exp2m1_pkg::*;
(
    input  logic                     op_sign,
    input  logic [MANT_W-1:0]        op_mant,
    input  logic signed [EACC_W-1:0] exp_start,
    input  logic [1:0]               rnd_mode,
    input  logic                     um,
    input  logic                     pm,
    output logic [EXP_W-1:0]         t_exp,
    output logic [MANT_W-1:0]        t_mant,
    output logic [STAT_W-1:0]        t_flags
);
    logic [PROD_W-1:0]        prod, norm;
    logic [LZ_W-1:0]          lz, sh;
    logic signed [EACC_W-1:0] lz_s, e1, e2, e3;
    logic [MANT_W-1:0]        hi, m2;
    logic [MANT_W:0]          sum;
    logic                     inexact, inc;
    logic [EACC_W-EXP_W-1:0]  unused_e3;

    // wide product with the sticky bit forced
    always_comb prod = ({{(2*MANT_W){1'b0}}, op_mant} * {{MANT_W{1'b0}}, LN2_SIG}) | {{(PROD_W-1){1'b0}}, 1'b1};

    // leading-zero count of the product
    always_comb begin
        lz = '0;
        for (int i = 0; i < PROD_W; i++)
            if (prod[i]) lz = LZ_W'(PROD_W - 1 - i);
    end

    // normalisation shift with the underflow-mask limit
    always_comb begin
        lz_s = EACC_W'(lz);
        if (prod[PROD_W-1]) begin
            sh = '0; e1 = exp_start;
        end else if (exp_start > lz_s) begin
            sh = lz; e1 = exp_start - lz_s;
        end else if (um) begin
            if (exp_start > 0) begin
                sh = LZ_W'(exp_start - 1); e1 = '0;
            end else begin
                sh = '0; e1 = exp_start;
            end
        end else begin
            sh = lz; e1 = exp_start - lz_s;
        end
        norm = prod << sh;
    end

    // rounding decision and increment
    always_comb begin
        hi      = norm[PROD_W-1:2*MANT_W];
        inexact = |norm[2*MANT_W-1:0];
        unique case (rnd_mode)
            2'b00:   inc = norm[2*MANT_W-1] && (hi[0] || (|norm[2*MANT_W-2:0]));
            2'b01:   inc = op_sign;
            2'b10:   inc = !op_sign;
            default: inc = 1'b0;
        endcase
        inc = inc && inexact;
        sum = {1'b0, hi} + {{MANT_W{1'b0}}, inc};
        if (sum[MANT_W]) begin
            m2 = MANT_ONE; e2 = e1 + 1;
        end else begin
            m2 = sum[MANT_W-1:0]; e2 = e1;
        end
    end

    // underflow handling and flag composition
    always_comb begin
        t_flags = '0;
        t_flags[SB_C1] = inc;
        t_flags[SB_PE] = inexact;
        t_flags[SB_ES] = inexact && !pm;
        t_flags[SB_B]  = inexact && !pm;
        t_mant = m2;
        e3     = e2;
        if (e2 <= 0) begin
            t_flags[SB_UE] = 1'b1;
            if (um) begin
                if (m2[MANT_W-1]) t_mant = m2 >> 1;
                e3 = '0;
            end else begin
                e3 = e2 + UFLOW_ADJ;
                t_flags[SB_ES] = 1'b1;
                t_flags[SB_B]  = 1'b1;
            end
        end
        t_exp = e3[EXP_W-1:0];
    end

    assign unused_e3 = e3[EACC_W-1:EXP_W];
endmodule

// File: rtl/exp2m1_front.sv
// Module: exp2m1_front (top)
// Front end of 2^x-1: classifies the operand, resolves every closed-form case
// and the tiny path, flags mid-range operands for the polynomial core.
// One register stage; result follows the operand by one clock.
module exp2m1_front
    import exp2m1_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic [STAT_W-1:0] ctrl_word,
    input  logic [STAT_W-1:0] stat_word,
    output logic              out_valid,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [MANT_W-1:0] res_mant,
    output logic [STAT_W-1:0] res_status,
    output logic              core_req
);
    opclass_e                 cls;
    logic                     is_snan, use_tiny, n_sign, n_req, im, dm, pm;
    logic [EXP_W-1:0]         n_exp, t_exp;
    logic [MANT_W-1:0]        n_mant, t_mant;
    logic [STAT_W-1:0]        n_stat, t_flags;
    logic signed [EACC_W-1:0] t_start;
    logic                     unused_bits;

    assign im = ctrl_word[CB_IM];
    assign dm = ctrl_word[CB_DM];
    assign pm = ctrl_word[CB_PM];
    assign unused_bits = ^{ctrl_word[15:12], ctrl_word[9:6], ctrl_word[3:2],
                           stat_word[15], stat_word[13:11], stat_word[9], stat_word[7:0]};

    exp2m1_classify u_cls (
        .op_exp(in_exp), .op_mant(in_mant), .op_class(cls), .op_snan(is_snan)
    );

    // tiny path starts from the operand exponent, or 1 for denormal encodings
    assign t_start = (cls == CL_NORMAL) ? EACC_W'(in_exp) : 20'sd1;

    exp2m1_tiny_round u_tiny (
        .op_sign(in_sign), .op_mant(in_mant), .exp_start(t_start),
        .rnd_mode(ctrl_word[CB_RC+1:CB_RC]), .um(ctrl_word[CB_UM]), .pm(pm),
        .t_exp(t_exp), .t_mant(t_mant), .t_flags(t_flags)
    );

    // per-class result and status selection
    always_comb begin
        n_sign   = in_sign;
        n_exp    = in_exp;
        n_mant   = in_mant;
        n_req    = 1'b0;
        use_tiny = 1'b0;
        n_stat   = '0;
        n_stat[SB_C0] = stat_word[SB_C0];
        n_stat[SB_C2] = stat_word[SB_C2];
        n_stat[SB_C3] = stat_word[SB_C3];
        n_stat[SB_TOP+2:SB_TOP] = 3'd7;
        unique case (cls)
            CL_NORMAL: begin
                if (in_exp < EXP_BIAS) begin
                    if (in_exp <= EXP_TINY) use_tiny = 1'b1;
                    else begin
                        n_req = 1'b1; n_sign = 1'b0; n_exp = '0; n_mant = '0;
                    end
                end else begin
                    if (in_exp == EXP_BIAS && in_mant == MANT_ONE)
                        n_exp = EXP_BIAS - EXP_W'(in_sign);
                    n_stat[SB_PE] = 1'b1;
                    n_stat[SB_ES] = !pm;
                    n_stat[SB_B]  = !pm;
                end
            end
            CL_ZERO, CL_NAN_Q: ;
            CL_INF: if (in_sign) begin
                n_exp = EXP_BIAS; n_mant = MANT_ONE;
            end
            CL_DENORM, CL_PDENORM: begin
                n_stat[SB_DE] = 1'b1;
                if (dm) use_tiny = 1'b1;
                else begin
                    n_stat[SB_ES] = 1'b1; n_stat[SB_B] = 1'b1;
                end
            end
            default: begin
                n_stat[SB_IE] = 1'b1;
                if (im) begin
                    if (is_snan) n_mant[MANT_W-2] = 1'b1;
                    else begin
                        n_sign = 1'b1; n_exp = EXP_MAX; n_mant = MANT_INDEF;
                    end
                end else begin
                    n_stat[SB_ES] = 1'b1; n_stat[SB_B] = 1'b1;
                end
            end
        endcase
        if (use_tiny) begin
            n_exp  = t_exp;
            n_mant = t_mant;
            n_stat = n_stat | t_flags;
        end
    end

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; core_req <= 1'b0; res_sign <= 1'b0;
            res_exp <= '0; res_mant <= '0; res_status <= '0;
        end else begin
            out_valid  <= in_valid;
            core_req   <= in_valid && n_req;
            res_sign   <= n_sign;
            res_exp    <= n_exp;
            res_mant   <= n_mant;
            res_status <= n_stat;
        end
    end
endmodule

// File: rtl/exp2m1_front_chk.sv
// Module: exp2m1_front_chk
// Temporal checks on the front end ports; attached to the top by bind.
module exp2m1_front_chk
    import exp2m1_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sign,
    input logic [EXP_W-1:0]  in_exp,
    input logic [MANT_W-1:0] in_mant,
    input logic [STAT_W-1:0] stat_word,
    input logic              out_valid,
    input logic              res_sign,
    input logic [EXP_W-1:0]  res_exp,
    input logic [MANT_W-1:0] res_mant,
    input logic [STAT_W-1:0] res_status,
    input logic              core_req
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_status_seed: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_status[SB_C0] == $past(stat_word[SB_C0]))
                  && (res_status[SB_C2] == $past(stat_word[SB_C2]))
                  && (res_status[SB_C3] == $past(stat_word[SB_C3]))
                  && (res_status[SB_TOP+2:SB_TOP] == 3'd7));
    a_r3_req_clean: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> out_valid && res_status[7:0] == '0 && !res_status[SB_C1] && !res_status[SB_B]);
    a_r5_es_with_b: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> res_status[SB_ES] == res_status[SB_B]);
    a_r10_pos_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sign && in_exp == EXP_MAX && in_mant == MANT_ONE)
        |=> !res_sign && res_exp == EXP_MAX && res_mant == MANT_ONE && !core_req);
endmodule

bind exp2m1_front exp2m1_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .stat_word(stat_word),
    .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
    .res_mant(res_mant), .res_status(res_status), .core_req(core_req)
);

// File: tb/sim_exp2m1_front.sv
module sim_exp2m1_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic [15:0] ctrl_word = '0;
    logic [15:0] stat_word = '0;
    logic        out_valid, res_sign, core_req;
    logic [14:0] res_exp;
    logic [63:0] res_mant;
    logic [15:0] res_status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exp2m1_front u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_mant(in_mant), .ctrl_word(ctrl_word),
        .stat_word(stat_word), .out_valid(out_valid), .res_sign(res_sign),
        .res_exp(res_exp), .res_mant(res_mant), .res_status(res_status),
        .core_req(core_req)
    );

    task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tiny path model built from R4..R6, stepping one bit at a time
    task automatic ref_tiny(input logic s, input int e0, input logic [63:0] m,
                            input logic [1:0] rc, input logic um, input logic pm,
                            output logic [14:0] ox, output logic [63:0] om,
                            inout logic [15:0] st);
        logic [191:0] p;
        logic [64:0]  sum;
        logic         up;
        int e, z;
        p = 192'(m) * {64'd0, 128'hB17217F7D1CF79ABC000000000000000};
        p[0] = 1'b1;
        z = 0;
        while (z < 191 && !p[191 - z]) z++;
        e = e0;
        if (z != 0) begin
            if (e > z) begin p = p << z; e = e - z; end
            else if (um) begin if (e > 0) begin p = p << (e - 1); e = 0; end end
            else begin p = p << z; e = e - z; end
        end
        om = p[191:128];
        if (p[127:0] != 0) begin
            case (rc)
                2'd0: up = p[127] && (om[0] || p[126:0] != 0);
                2'd1: up = s;
                2'd2: up = !s;
                default: up = 1'b0;
            endcase
            if (up) begin
                sum = {1'b0, om} + 65'd1;
                if (sum[64]) begin om = 64'h8000000000000000; e++; end
                else om = sum[63:0];
                st[9] = 1'b1;
            end
            st[5] = 1'b1;
            if (!pm) begin st[7] = 1'b1; st[15] = 1'b1; end
        end
        if (e <= 0) begin
            st[4] = 1'b1;
            if (um) begin if (om[63]) om = om >> 1; e = 0; end
            else begin e = e + 24576; st[7] = 1'b1; st[15] = 1'b1; end
        end
        ox = 15'(e);
    endtask

    // full expected result from the requirement list
    task automatic ref_model(input logic s, input logic [14:0] e, input logic [63:0] m,
                             input logic [15:0] cw, input logic [15:0] sw,
                             output logic [159:0] res, output string tag);
        logic        rs, rq;
        logic [14:0] rx;
        logic [63:0] rm;
        logic [15:0] st;
        bit          tiny;
        rs = s; rx = e; rm = m; rq = 1'b0; tiny = 1'b0;
        st = (sw & 16'h4500) | 16'h3800;
        if (e == 0 && m == 0) tag = "R9";
        else if (e == 0) begin
            tag = "R11"; st[1] = 1'b1;
            if (cw[1]) tiny = 1'b1; else begin st[7] = 1'b1; st[15] = 1'b1; end
        end else if (e == 15'h7FFF && m == 64'h8000000000000000) begin
            tag = "R10";
            if (s) begin rx = 15'd16383; end
        end else if (e == 15'h7FFF && m[63] && m[62]) tag = "R9";
        else if (e != 15'h7FFF && m[63]) begin
            if (e <= 15'd16314) begin tag = "R4 R5"; tiny = 1'b1; end
            else if (e < 15'd16383) begin
                tag = "R3"; rq = 1'b1; rs = 1'b0; rx = 0; rm = 0;
            end else begin
                if (e == 15'd16383 && m == 64'h8000000000000000) begin
                    tag = "R7"; rx = 15'd16383 - 15'(s);
                end else tag = "R8";
                st[5] = 1'b1;
                if (!cw[5]) begin st[7] = 1'b1; st[15] = 1'b1; end
            end
        end else begin
            tag = "R12"; st[0] = 1'b1;
            if (!cw[0]) begin st[7] = 1'b1; st[15] = 1'b1; end
            else if (e == 15'h7FFF && m[63]) rm[62] = 1'b1;
            else begin rs = 1'b1; rx = 15'h7FFF; rm = 64'hC000000000000000; end
        end
        if (tiny) begin
            ref_tiny(s, (e == 0) ? 1 : int'(e), m, cw[11:10], cw[4], cw[5], rx, rm, st);
            if (st[4]) tag = "R6";
        end
        res = {rq, rs, rx, rm, st, 63'd0};
    endtask

    task automatic apply(input logic s, input logic [14:0] e, input logic [63:0] m,
                         input logic [15:0] cw, input logic [15:0] sw);
        logic [159:0] expv;
        string        tag;
        ref_model(s, e, m, cw, sw, expv, tag);
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_exp = e; in_mant = m;
        ctrl_word = cw; stat_word = sw;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {159'd0, out_valid}, 160'd1);
        check(tag, {core_req, res_sign, res_exp, res_mant, res_status, 63'd0}, expv);
        check("R1 seed", {144'd0, res_status & 16'h7D00}, {144'd0, (sw & 16'h4500) | 16'h3800});
        @(negedge clk);
        check("R2 idle", {158'd0, out_valid, core_req}, 160'd0);
    endtask

    logic [79:0] pats [0:25];

    initial begin
        pats[0]  = {1'b0, 15'h0000, 64'h0};
        pats[1]  = {1'b1, 15'h0000, 64'h0};
        pats[2]  = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
        pats[3]  = {1'b1, 15'h0000, 64'h7FFF_FFFF_FFFF_FFFF};
        pats[4]  = {1'b0, 15'h0000, 64'h8000_0000_0000_0001};
        pats[5]  = {1'b0, 15'd1,     64'h8000_0000_0000_0000};
        pats[6]  = {1'b1, 15'd2,     64'hFFFF_FFFF_FFFF_FFFF};
        pats[7]  = {1'b0, 15'd100,   64'hC3A5_5A3C_1234_5678};
        pats[8]  = {1'b1, 15'd16314, 64'h8000_0000_0000_0000};
        pats[9]  = {1'b0, 15'd16314, 64'hFFFF_FFFF_FFFF_FFFF};
        pats[10] = {1'b0, 15'd16315, 64'h8000_0000_0000_0000};
        pats[11] = {1'b1, 15'd16382, 64'hFFFF_FFFF_FFFF_FFFF};
        pats[12] = {1'b0, 15'd16383, 64'h8000_0000_0000_0000};
        pats[13] = {1'b1, 15'd16383, 64'h8000_0000_0000_0000};
        pats[14] = {1'b0, 15'd16383, 64'h8000_0000_0000_0001};
        pats[15] = {1'b1, 15'd20000, 64'hA000_0000_0000_0000};
        pats[16] = {1'b0, 15'd500,   64'h4000_0000_0000_0000};
        pats[17] = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
        pats[18] = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
        pats[19] = {1'b0, 15'h7FFF, 64'h4000_0000_0000_0000};
        pats[20] = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0005};
        pats[21] = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0009};
        pats[22] = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
        pats[23] = {1'b0, 15'h7FFF, 64'h0000_0000_0000_0000};
        pats[24] = {1'b1, 15'd12345, 64'h9E37_79B9_7F4A_7C15};
        pats[25] = {1'b0, 15'd3,     64'h8000_0000_0000_0001};

        repeat (3) @(negedge clk);
        check("R2 reset", {158'd0, out_valid, core_req}, 160'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset", {159'd0, out_valid}, 160'd0);

        for (int rc = 0; rc < 4; rc++) begin
            for (int k = 0; k < 4; k++) begin
                logic [5:0] msk;
                case (k)
                    0: msk = 6'h3F;
                    1: msk = 6'h00;
                    2: msk = 6'h2F;
                    default: msk = 6'h1C;
                endcase
                for (int w = 0; w < 2; w++) begin
                    for (int i = 0; i < 26; i++) begin
                        apply(pats[i][79], pats[i][78:64], pats[i][63:0],
                              16'(rc << 10) | 16'h0340 | {10'd0, msk},
                              w ? 16'hFFFF : 16'h0000);
                    end
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule